// File: doc/BRIEF.md
# SDRAM Read-Burst Precharge Scheduler

This block sequences the commands for one read on a single SDRAM bank. It takes one request, which carries a bank, a row, a column, a count of wanted words, a burst mode, an auto-precharge flag and a CAS latency. It opens the row with ACTIVE and reads with READ. It then closes the row by one of two means. The first is an explicit PRECHARGE placed so that the burst stops after the last wanted word. The second is the device's own auto-precharge. The block keeps the bank blocked for the row precharge time before the next ACTIVE may go out.

The explicit PRECHARGE goes out CAS latency minus one cycles before the cycle that carries the last wanted word. Counted from the READ, this is always the number of wanted words, whatever the latency. Part of the precharge time therefore overlaps the final data transfers. The same rule cuts a fixed-length burst short and ends a full-page burst, which never stops without a PRECHARGE. A strobe marks each cycle in which a wanted word returns. A byte-mask output stays low while read data is due. Requests that cannot be honoured are refused with a one-cycle error pulse.

Top module: `rdburst_pre_sched`

## Requirements
- R1: The command bus `cmd_op` is two bits: 0 = NOP, 1 = ACTIVE, 2 = READ, 3 = PRECHARGE. Every cycle that carries no scheduled command, the reset cycles included, drives NOP. While reset is high, `data_valid` and `req_err` are low.
- R2: A good request accepted on a clock edge puts ACTIVE on the bus in the cycle after that edge, with the row on `cmd_addr` and the bank on `cmd_bank`. READ follows exactly T_RCD cycles after ACTIVE, with the column zero-extended on `cmd_addr` and `cmd_ap` equal to the request's auto-precharge flag.
- R3: `cas_lat` (1, 2 or 3) is captured at acceptance. `data_valid` is high for exactly `req_len` consecutive cycles, starting `cas_lat` cycles after the READ cycle.
- R4: Without auto-precharge, PRECHARGE appears `req_len` cycles after READ. This is `cas_lat`−1 cycles before the last wanted word, for every supported latency. A fixed burst shorter than BURST_LEN is cut short this way.
- R5: In full-page mode (`req_fullpage`=1), lengths up to PAGE_WORDS are accepted. The burst ends only through the PRECHARGE of R4.
- R6: After a PRECHARGE cycle P, the next ACTIVE cannot appear before P+T_RP. A request that is waiting gets its ACTIVE exactly at P+T_RP.
- R7: With auto-precharge, no PRECHARGE is driven. The recovery count starts in the cycle after the last word of the full BURST_LEN burst, so a waiting request gets its ACTIVE at READ+`cas_lat`+BURST_LEN+T_RP.
- R8: A request is refused under any of these conditions: `req_len`=0, `cas_lat`=0, a fixed burst longer than BURST_LEN, a full-page burst longer than PAGE_WORDS, or full-page with auto-precharge. A refused request pulses `req_err` for one cycle, the cycle after acceptance, issues no command, and leaves the block ready again in that same cycle.
- R9: `dq_mask` is low from the READ cycle through the last wanted word, and high when no read is outstanding.
- R10: `req_ready` is high only when the block is idle and the recovery time has elapsed. It drops in the ACTIVE cycle. A request held while `req_ready` is low is neither taken nor lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request taken on the edge where valid and ready are both high |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_len | input | LEN_W | Number of wanted words |
| req_fullpage | input | 1 | 1 = full-page burst, 0 = fixed burst of BURST_LEN |
| req_autopre | input | 1 | Close the row by auto-precharge |
| cas_lat | input | 2 | CAS latency for this read |
| req_err | output | 1 | One-cycle refusal pulse |
| cmd_op | output | 2 | Command code (R1) |
| cmd_bank | output | BANK_W | Bank field |
| cmd_addr | output | ADDR_W | Row or column field |
| cmd_ap | output | 1 | Auto-precharge bit on READ |
| dq_mask | output | 1 | Byte mask, low while read data is due |
| data_valid | output | 1 | A wanted word is on the data bus |

## Verification
With CAS latency 3 and the default recovery time of two cycles, the ACTIVE of a waiting request lands in the same cycle as the last wanted word of the previous burst. The bench provokes this by queueing the next request behind a CL=3 read. It then expects, in that one cycle, ACTIVE on the bus, `data_valid` high and `dq_mask` low. A second coincidence comes from changing the CAS latency between back-to-back bursts. Words of the old latency are still in flight when the new latency is captured, and every word must still arrive in the cycle its own latency sets.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_BURST = 2'd2
    } sched_st_e;

    localparam int MAX_CL = 3;

    // Returns 1 when a request cannot be served.
    function automatic logic req_is_bad(input int len, input logic fullpage,
                                        input logic autopre, input int cl,
                                        input int burst_len, input int page_words);
        logic bad;
        bad = (len == 0) || (cl == 0) || (cl > MAX_CL);
        if (fullpage) bad = bad || autopre || (len > page_words);
        else          bad = bad || (len > burst_len);
        return bad;
    endfunction

endpackage

// File: rtl/rbp_req_check.sv
module rbp_req_check #(
    parameter int LEN_W      = 9,
    parameter int BURST_LEN  = 4,
    parameter int PAGE_WORDS = 256
) (
    input  logic [LEN_W-1:0] len,
    input  logic             fullpage,
    input  logic             autopre,
    input  logic [1:0]       cl,
    output logic             bad
);
    import rbp_pkg::*;

    always_comb begin
        bad = req_is_bad(int'(len), fullpage, autopre, int'(cl), BURST_LEN, PAGE_WORDS);
    end
endmodule

// File: rtl/rbp_rp_timer.sv
module rbp_rp_timer #(
    parameter int T_RP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = (T_RP < 2) ? 1 : $clog2(T_RP + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= CW'(T_RP - 1);
        else if (cnt != '0)     cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/rbp_dv_pipe.sv
module rbp_dv_pipe #(
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       word_in,
    input  logic [1:0] cl,
    output logic       dv_out,
    output logic       pending
);
    logic [DEPTH-1:0] sr;
    logic [DEPTH-1:0] ins;

    // Each word enters at the tap that leaves exactly cl stages to the output.
    for (genvar j = 0; j < DEPTH; j++) begin : g_tap
        assign ins[j] = word_in && (int'(cl) == DEPTH - j);
    end

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], 1'b0} | ins;
    end

    assign dv_out  = sr[DEPTH-1];
    assign pending = |sr;
endmodule

// File: rtl/rdburst_pre_sched.sv
module rdburst_pre_sched #(
    parameter int BANK_W     = 1,
    parameter int ROW_W      = 11,
    parameter int COL_W      = 8,
    parameter int BURST_LEN  = 4,
    parameter int PAGE_WORDS = 256,
    parameter int T_RP       = 2,
    parameter int T_RCD      = 2,
    parameter int LEN_W      = $clog2(PAGE_WORDS + 1),
    parameter int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_fullpage,
    input  logic              req_autopre,
    input  logic [1:0]        cas_lat,
    output logic              req_err,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ap,
    output logic              dq_mask,
    output logic              data_valid
);
    import rbp_pkg::*;

    localparam int CNT_W = LEN_W + 2;

    sched_st_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_q;
    logic              ap_q;
    logic [1:0]        cl_q;
    logic [COL_W-1:0]  col_q;
    logic [BANK_W-1:0] bank_q;
    sd_cmd_e           cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              ap_bit_q;
    logic              err_q;

    logic bad, rp_busy, accept, word_now, pipe_pending;
    logic pre_now, auto_end, rp_load;

    rbp_req_check #(.LEN_W(LEN_W), .BURST_LEN(BURST_LEN), .PAGE_WORDS(PAGE_WORDS)) u_chk_req (
        .len(req_len), .fullpage(req_fullpage), .autopre(req_autopre),
        .cl(cas_lat), .bad(bad)
    );

    assign req_ready = !rst && (state == ST_IDLE) && !rp_busy;
    assign accept    = req_valid && req_ready;

    // Explicit precharge: req_len cycles after READ (CL-1 before last word).
    assign pre_now  = (state == ST_BURST) && !ap_q &&
                      (cnt == CNT_W'(len_q) - CNT_W'(1));
    // Auto-precharge: recovery starts the cycle after the last burst word.
    assign auto_end = (state == ST_BURST) && ap_q &&
                      (cnt == CNT_W'(cl_q) + CNT_W'(BURST_LEN) - CNT_W'(1));
    assign rp_load  = pre_now || auto_end;
    assign word_now = (state == ST_BURST) && (cnt < CNT_W'(len_q));

    rbp_rp_timer #(.T_RP(T_RP)) u_rp (
        .clk(clk), .rst(rst), .load(rp_load), .busy(rp_busy)
    );

    rbp_dv_pipe #(.DEPTH(MAX_CL)) u_dv (
        .clk(clk), .rst(rst), .word_in(word_now), .cl(cl_q),
        .dv_out(data_valid), .pending(pipe_pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            ap_q     <= 1'b0;
            cl_q     <= 2'd1;
            col_q    <= '0;
            bank_q   <= '0;
            cmd_q    <= CMD_NOP;
            addr_q   <= '0;
            ap_bit_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            cmd_q    <= CMD_NOP;
            addr_q   <= '0;
            ap_bit_q <= 1'b0;
            err_q    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (bad) begin
                            err_q <= 1'b1;
                        end else begin
                            state  <= ST_OPEN;
                            cmd_q  <= CMD_ACT;
                            addr_q <= ADDR_W'(req_row);
                            bank_q <= req_bank;
                            col_q  <= req_col;
                            len_q  <= req_len;
                            ap_q   <= req_autopre;
                            cl_q   <= cas_lat;
                            cnt    <= '0;
                        end
                    end
                end
                ST_OPEN: begin
                    if (cnt == CNT_W'(T_RCD - 1)) begin
                        state    <= ST_BURST;
                        cmd_q    <= CMD_RD;
                        addr_q   <= ADDR_W'(col_q);
                        ap_bit_q <= ap_q;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_BURST: begin
                    cnt <= cnt + CNT_W'(1);
                    if (pre_now) begin
                        cmd_q <= CMD_PRE;
                        state <= ST_IDLE;
                    end else if (auto_end) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_op   = cmd_q;
    assign cmd_bank = bank_q;
    assign cmd_addr = addr_q;
    assign cmd_ap   = ap_bit_q;
    assign req_err  = err_q;
    assign dq_mask  = !((state == ST_BURST) || pipe_pending);
endmodule

// File: rtl/rbp_sched_chk.sv
module rbp_sched_chk #(
    parameter int T_RP  = 2,
    parameter int T_RCD = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_err,
    input logic [1:0] cmd_op,
    input logic       dq_mask,
    input logic       data_valid
);
    import rbp_pkg::*;

    logic [15:0] pre_gap;
    logic [15:0] act_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_gap <= 16'(T_RP);
            act_gap <= 16'(T_RCD);
        end else begin
            if (cmd_op == CMD_PRE)            pre_gap <= 16'd1;
            else if (pre_gap < 16'(T_RP))     pre_gap <= pre_gap + 16'd1;
            if (cmd_op == CMD_ACT)            act_gap <= 16'd1;
            else if (act_gap < 16'(T_RCD))    act_gap <= act_gap + 16'd1;
        end
    end

    assert_act_after_rp_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_ACT) |-> (pre_gap >= 16'(T_RP)));

    assert_rd_after_rcd_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_RD) |-> (act_gap == 16'(T_RCD)));

    assert_err_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        req_err |-> $past(req_valid && req_ready));

    assert_err_no_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (cmd_op == CMD_NOP));

    assert_dv_unmasked_R9: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> !dq_mask);

    assert_act_drops_ready_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_ACT) |-> !req_ready);
endmodule

bind rdburst_pre_sched rbp_sched_chk #(.T_RP(T_RP), .T_RCD(T_RCD)) u_sched_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_err(req_err), .cmd_op(cmd_op), .dq_mask(dq_mask), .data_valid(data_valid)
);

// File: tb/sim_rdburst_pre_sched.sv
module sim_rdburst_pre_sched;
    localparam int BANK_W = 1, ROW_W = 11, COL_W = 8;
    localparam int BL = 4, PAGE = 256, T_RP = 2, T_RCD = 2;
    localparam int LEN_W = $clog2(PAGE + 1);
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic req_fullpage = 0, req_autopre = 0;
    logic [1:0] cas_lat = 2'd1;
    logic req_err, cmd_ap, dq_mask, data_valid;
    logic [1:0] cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;

    rdburst_pre_sched u0 (.*);

    always #5 clk = ~clk;

    typedef struct {
        int    cyc;
        int    op;
        int    addr;
        int    bank;
        int    ap;
        string tag;
    } cmd_item_t;

    cmd_item_t cq[$];
    int dq[$];
    int eq[$];
    int cyc = 0, checks = 0, fails = 0, next_ok = 0;
    bit mon_on = 0, done = 0;
    string act_tag = "R2";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic send(input int row, input int col, input int len, input bit fp,
                        input bit ap, input int cl, input int bank, input bit bad);
        int e, r;
        req_row = ROW_W'(row); req_col = COL_W'(col); req_len = LEN_W'(len);
        req_fullpage = fp; req_autopre = ap; cas_lat = 2'(cl);
        req_bank = BANK_W'(bank); req_valid = 1;
        e = (cyc + 1 > next_ok) ? cyc + 1 : next_ok;
        if (bad) begin
            eq.push_back(e);
            next_ok = e + 1;
        end else begin
            r = e + T_RCD;
            cq.push_back('{e, 1, row, bank, 0, act_tag});
            cq.push_back('{r, 2, col, bank, int'(ap), "R2"});
            for (int k = 0; k < len; k++) dq.push_back(r + cl + k);
            if (!ap) begin
                cq.push_back('{r + len, 3, 0, bank, 0, fp ? "R5" : "R4"});
                next_ok = r + len + T_RP;
                act_tag = "R6";
            end else begin
                next_ok = r + cl + BL + T_RP;
                act_tag = "R7";
            end
        end
        while (cyc < e) @(negedge clk);
        req_valid = 0;
    endtask

    // Monitor: pops expected items as the design produces them.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (cq.size() > 0 && cq[0].cyc == cyc) begin
                chk(int'(cmd_op) == cq[0].op, cq[0].tag, "cmd_op", int'(cmd_op), cq[0].op);
                if (cq[0].op != 3)
                    chk(int'(cmd_addr) == cq[0].addr, cq[0].tag, "cmd_addr", int'(cmd_addr), cq[0].addr);
                if (cq[0].op == 1) begin
                    chk(int'(cmd_bank) == cq[0].bank, "R2", "cmd_bank", int'(cmd_bank), cq[0].bank);
                    chk(req_ready == 1'b0, "R10", "ready in ACTIVE cycle", int'(req_ready), 0);
                end
                if (cq[0].op == 2)
                    chk(int'(cmd_ap) == cq[0].ap, "R2", "cmd_ap", int'(cmd_ap), cq[0].ap);
                void'(cq.pop_front());
            end else begin
                chk(cmd_op == 2'd0, "R1", "idle cmd_op", int'(cmd_op), 0);
            end
            if (dq.size() > 0 && dq[0] == cyc) begin
                chk(data_valid == 1'b1, "R3", "data_valid", int'(data_valid), 1);
                chk(dq_mask == 1'b0, "R9", "dq_mask during data", int'(dq_mask), 0);
                void'(dq.pop_front());
            end else begin
                chk(data_valid == 1'b0, "R3", "data_valid idle", int'(data_valid), 0);
            end
            if (eq.size() > 0 && eq[0] == cyc) begin
                chk(req_err == 1'b1, "R8", "req_err", int'(req_err), 1);
                void'(eq.pop_front());
            end else begin
                chk(req_err == 1'b0, "R8", "req_err idle", int'(req_err), 0);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_op == 2'd0, "R1", "reset cmd_op", int'(cmd_op), 0);
        chk(data_valid == 1'b0, "R1", "reset data_valid", int'(data_valid), 0);
        chk(req_err == 1'b0, "R1", "reset req_err", int'(req_err), 0);
        chk(req_ready == 1'b0, "R10", "ready in reset", int'(req_ready), 0);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
        mon_on = 1;
        next_ok = cyc + 1;

        send(11'h123, 8'h10, 4, 0, 0, 1, 1, 0);   // R4 CL=1 full fixed burst
        send(11'h045, 8'h22, 2, 0, 0, 2, 0, 0);   // R4 truncated, CL=2
        send(11'h3ff, 8'h31, 4, 0, 0, 3, 1, 0);   // R3 CL=3: next ACT meets last word
        send(11'h200, 8'h40, 1, 0, 0, 2, 0, 0);   // R6 single word after CL=3 burst
        send(11'h011, 8'h05, 10, 1, 0, 3, 1, 0);  // R5 full-page
        send(11'h0aa, 8'h0c, 4, 0, 1, 2, 0, 0);   // R7 auto-precharge
        send(11'h155, 8'h77, 2, 0, 1, 3, 1, 0);   // R7 auto-precharge short
        send(11'h001, 8'h01, 3, 0, 0, 1, 0, 0);   // R6 after auto
        send(0, 0, 0, 0, 0, 2, 0, 1);             // R8 zero length
        send(0, 0, 5, 0, 0, 2, 0, 1);             // R8 fixed too long
        send(0, 0, 257, 1, 0, 2, 0, 1);           // R8 page too long
        send(0, 0, 8, 1, 1, 2, 0, 1);             // R8 full-page with auto
        send(0, 0, 2, 0, 0, 0, 0, 1);             // R8 latency zero
        send(11'h7ff, 8'hff, 256, 1, 0, 1, 1, 0); // R5 whole page
        send(11'h321, 8'h02, 4, 0, 0, 3, 0, 0);   // R6 after page

        while (cq.size() > 0 || dq.size() > 0 || eq.size() > 0) @(negedge clk);
        repeat (6) @(negedge clk);
        done = 1;
        chk(dq_mask == 1'b1, "R9", "dq_mask idle", int'(dq_mask), 1);
        chk(req_ready == 1'b1, "R10", "ready at end", int'(req_ready), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule